// File: doc/BRIEF.md
# Skewed Cyclic-Shift Matrix Transposer

This block turns a square matrix held one row per lane into the same matrix held one column per lane. It is meant to sit between the row pass and the column pass of a two-dimensional FFT. Before a run, each of the `LANES` lanes is loaded with one row. After the run, lane `w` holds column `w`, so the second pass can work on whole columns from local storage.

The exchange runs as a fixed schedule. The first cycle copies each lane's diagonal word into its own destination slot without using the network. Each of the next `LANES-1` cycles is one uniform cyclic shift by the step number. In step `i`, lane `h` sends the word at its source column `(h+i) mod LANES`. A barrel rotator delivers that word to lane `(h+i) mod LANES` in a single pass. The receiving lane `r` writes it at destination slot `(r-i) mod LANES`. Because `LANES` is a power of two, every modulo is a plain truncation of the lane-index width.

The source buffers keep their contents after a run. A second start without reloading therefore produces the same result again. While a run is in progress, loads are ignored and the readout port returns zero.

Top module: `tp_transposer`

## Requirements
- R1: When `busy` is low, a cycle with `ld_en` high writes `ld_data` into the source buffer of lane `ld_lane` at column `ld_col`.
- R2: A `start` sampled while `busy` is low raises `busy` on the next cycle. `busy` then stays high for exactly `LANES` cycles.
- R3: `done` is high for exactly one cycle, and that cycle is the first one in which `busy` is low again.
- R4: After `done`, reading with `rd_lane = w` and `rd_pos = h` returns the word that was loaded at lane `h`, column `w`, for every `h` different from `w`.
- R5: After `done`, reading with `rd_lane = rd_pos = h` returns the word loaded at lane `h`, column `h`. This diagonal word is moved by a local copy.
- R6: A load issued while `busy` is high changes no source buffer. A second run started without reloading returns the same transposed matrix.
- R7: A `start` issued while `busy` is high is ignored. The run in progress still lasts exactly `LANES` cycles.
- R8: While `busy` is high, `rd_data` reads zero for any lane and position.
- R9: After reset, `busy` and `done` are low, and every destination word and every source word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Source-word write strobe |
| ld_lane | input | $clog2(LANES) | Lane (row) being loaded |
| ld_col | input | $clog2(LANES) | Column within the row being loaded |
| ld_data | input | DATA_W | Word to load |
| start | input | 1 | Begin a transpose run |
| rd_lane | input | $clog2(LANES) | Lane (column) to read out |
| rd_pos | input | $clog2(LANES) | Position (row) within that column |
| rd_data | output | DATA_W | Destination word; zero while busy |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The assertions assume only that `start` is a clean synchronous level. Pulses may arrive in any cycle, including while a run is in progress and in the cycle where `done` is high. The cycle-count check relies on an internal run counter rather than a long `$past`. The bench drives every input just after a rising edge, so every start and load is sampled as a whole cycle.

The stimulus deliberately includes starts and loads inside a run, so that the run-length and the ignored-load properties are exercised as well as the clean case.

// File: rtl/tp_pkg.sv
// Shared helpers for the cyclic-shift transposer.
// Assumes the lane count is a power of two of at least 2.
package tp_pkg;
    // Width of a lane index; never below one bit.
    function automatic int idx_width(input int lanes);
        return (lanes > 2) ? $clog2(lanes) : 1;
    endfunction
endpackage

// File: rtl/tp_rotator.sv
// Barrel rotator over LANES ports: out[j] = in[(j - amt) mod LANES].
// Built as log2(LANES) stages, each rotating by a power of two.
// Purely combinational. Assumes LANES is a power of two.
module tp_rotator #(
    parameter int LANES  = 8,
    parameter int DATA_W = 16
) (
    input  logic [LANES-1:0][DATA_W-1:0]        in_bus,
    input  logic [tp_pkg::idx_width(LANES)-1:0] amt,
    output logic [LANES-1:0][DATA_W-1:0]        out_bus
);
    localparam int STAGES = tp_pkg::idx_width(LANES);

    logic [STAGES:0][LANES-1:0][DATA_W-1:0] stg;

    assign stg[0]  = in_bus;
    assign out_bus = stg[STAGES];

    // Stage k rotates by 2**k lanes when bit k of the amount is set.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        for (genvar j = 0; j < LANES; j++) begin : g_port
            localparam int SRC = (j - (1 << k) + 2 * LANES) % LANES;
            assign stg[k+1][j] = amt[k] ? stg[k][SRC] : stg[k][j];
        end
    end
endmodule

// File: rtl/tp_lane.sv
// One lane: a source row buffer and a destination column buffer.
// During a run it sends src[(ID+step) mod LANES] to the network.
// It writes the incoming word at dst[(ID-step) mod LANES].
// Step 0 takes its own outgoing word (the diagonal copy) and bypasses the network.
module tp_lane #(
    parameter int LANES   = 8,
    parameter int DATA_W  = 16,
    parameter int LANE_ID = 0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [tp_pkg::idx_width(LANES)-1:0] wr_col,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic                                xfer_en,
    input  logic [tp_pkg::idx_width(LANES)-1:0] step,
    output logic [DATA_W-1:0]                   tx_word,
    input  logic [DATA_W-1:0]                   rx_word,
    input  logic [tp_pkg::idx_width(LANES)-1:0] rd_pos,
    output logic [DATA_W-1:0]                   rd_word
);
    localparam int IDX_W = tp_pkg::idx_width(LANES);
    localparam logic [IDX_W-1:0] MY_ID = IDX_W'(LANE_ID);

    logic [DATA_W-1:0] src_mem [LANES];
    logic [DATA_W-1:0] dst_mem [LANES];
    logic [IDX_W-1:0]  src_sel;
    logic [IDX_W-1:0]  dst_sel;
    logic [DATA_W-1:0] wr_word;

    // Skewed addressing; wrap-around comes from index truncation.
    always_comb begin
        src_sel = MY_ID + step;
        dst_sel = MY_ID - step;
        tx_word = src_mem[src_sel];
        wr_word = (step == '0) ? tx_word : rx_word;
        rd_word = dst_mem[rd_pos];
    end

    // Source buffer: cleared on reset, written by the load port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < LANES; c++) src_mem[c] <= '0;
        end else if (wr_en) begin
            src_mem[wr_col] <= wr_data;
        end
    end

    // Destination buffer: cleared on reset, written once per run step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < LANES; c++) dst_mem[c] <= '0;
        end else if (xfer_en) begin
            dst_mem[dst_sel] <= wr_word;
        end
    end
endmodule

// File: rtl/tp_sequencer.sv
// Run controller: counts steps 0..LANES-1 while busy.
// At the end it drops busy and pulses done.
// A start is accepted only while idle.
module tp_sequencer #(
    parameter int LANES = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    output logic                                busy,
    output logic                                done,
    output logic [tp_pkg::idx_width(LANES)-1:0] step
);
    localparam int IDX_W = tp_pkg::idx_width(LANES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

    // Step counter and run/done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            step <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    step <= '0;
                end
            end else begin
                step <= step + 1'b1;
                if (step == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tp_transposer.sv
// Top: LANES lanes joined by a barrel rotator, driven by a step sequencer.
// Loads and readouts are blocked while a run is in progress.
// Assumes LANES is a power of two.
module tp_transposer #(
    parameter int LANES  = 8,
    parameter int DATA_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ld_en,
    input  logic [tp_pkg::idx_width(LANES)-1:0] ld_lane,
    input  logic [tp_pkg::idx_width(LANES)-1:0] ld_col,
    input  logic [DATA_W-1:0]                   ld_data,
    input  logic                                start,
    input  logic [tp_pkg::idx_width(LANES)-1:0] rd_lane,
    input  logic [tp_pkg::idx_width(LANES)-1:0] rd_pos,
    output logic [DATA_W-1:0]                   rd_data,
    output logic                                busy,
    output logic                                done
);
    localparam int IDX_W = tp_pkg::idx_width(LANES);

    logic [IDX_W-1:0]              step;
    logic [LANES-1:0][DATA_W-1:0]  tx_bus;
    logic [LANES-1:0][DATA_W-1:0]  rx_bus;
    logic [LANES-1:0][DATA_W-1:0]  rd_bus;

    tp_sequencer #(.LANES(LANES)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .step  (step)
    );

    tp_rotator #(.LANES(LANES), .DATA_W(DATA_W)) rot_i (
        .in_bus  (tx_bus),
        .amt     (step),
        .out_bus (rx_bus)
    );

    // One lane per matrix row / column.
    for (genvar h = 0; h < LANES; h++) begin : g_lane
        tp_lane #(.LANES(LANES), .DATA_W(DATA_W), .LANE_ID(h)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ld_en && !busy && (ld_lane == IDX_W'(h))),
            .wr_col  (ld_col),
            .wr_data (ld_data),
            .xfer_en (busy),
            .step    (step),
            .tx_word (tx_bus[h]),
            .rx_word (rx_bus[h]),
            .rd_pos  (rd_pos),
            .rd_word (rd_bus[h])
        );
    end

    // Readout mux, forced to zero during a run.
    always_comb begin
        rd_data = busy ? '0 : rd_bus[rd_lane];
    end
endmodule

// File: rtl/tp_transposer_chk.sv
// Protocol checker for tp_transposer: run length, done pulse, start acceptance
// and blocked readout. Bound to every instance of the top module.
module tp_transposer_chk #(
    parameter int LANES  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(LANES + 1) + 1;

    logic [CNT_W-1:0] run_len;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == CNT_W'(LANES)));

    // R3
    done_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    rd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data == '0));
endmodule

bind tp_transposer tp_transposer_chk #(.LANES(LANES), .DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/tp_transposer_tb.sv
module tp_transposer_tb_top;
    localparam int LANES  = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = tp_pkg::idx_width(LANES);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_en = 1'b0;
    logic [IDX_W-1:0]  ld_lane = '0;
    logic [IDX_W-1:0]  ld_col = '0;
    logic [DATA_W-1:0] ld_data = '0;
    logic              start = 1'b0;
    logic [IDX_W-1:0]  rd_lane = '0;
    logic [IDX_W-1:0]  rd_pos = '0;
    logic [DATA_W-1:0] rd_data;
    logic              busy;
    logic              done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] model [LANES][LANES];   // model[row][col]

    always #2 clk = ~clk;   // 250 MHz

    tp_transposer #(.LANES(LANES), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_lane(ld_lane),
        .ld_col(ld_col), .ld_data(ld_data), .start(start),
        .rd_lane(rd_lane), .rd_pos(rd_pos), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] expected_at(input int lane, input int pos);
        return model[pos][lane];
    endfunction

    task automatic load_word(input int row, input int col, input logic [DATA_W-1:0] val);
        ld_en = 1'b1; ld_lane = IDX_W'(row); ld_col = IDX_W'(col); ld_data = val;
        @(posedge clk); #1;
        ld_en = 1'b0;
        model[row][col] = val;
    endtask

    // Runs one transpose; poke adds a load and a start inside the run (R6, R7).
    task automatic run_xfer(input bit poke);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        for (int c = 1; c < LANES; c++) begin
            if (poke && c == 2) begin
                ld_en = 1'b1; ld_lane = 1; ld_col = 3; ld_data = ~model[1][3];
            end
            if (poke && c == 3) start = 1'b1;
            rd_lane = IDX_W'(c); rd_pos = IDX_W'(LANES - c);
            #0.5;
            chk(rd_data === '0, "R8 readout zero while busy", rd_data, 0);
            @(posedge clk); #1;
            ld_en = 1'b0; start = 1'b0;
            chk(busy === 1'b1, "R2 R7 busy held", busy, 1);
            chk(done === 1'b0, "R3 no early done", done, 0);
        end
        @(posedge clk); #1;
        chk(busy === 1'b0, "R2 busy ends after LANES cycles", busy, 0);
        chk(done === 1'b1, "R3 done after run", done, 1);
        @(posedge clk); #1;
        chk(done === 1'b0, "R3 done single cycle", done, 0);
        chk(busy === 1'b0, "R7 no restart from ignored start", busy, 0);
    endtask

    task automatic verify_all();
        for (int w = 0; w < LANES; w++) begin
            for (int h = 0; h < LANES; h++) begin
                rd_lane = IDX_W'(w); rd_pos = IDX_W'(h);
                #0.5;
                if (w == h)
                    chk(rd_data === expected_at(w, h), "R5 diagonal", rd_data, expected_at(w, h));
                else
                    chk(rd_data === expected_at(w, h), "R1 R4 transposed word", rd_data, expected_at(w, h));
            end
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < LANES; r++)
            for (int c = 0; c < LANES; c++) model[r][c] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 reset state
        chk(busy === 1'b0, "R9 busy low", busy, 0);
        chk(done === 1'b0, "R9 done low", done, 0);
        verify_all();
        run_xfer(1'b0);
        verify_all();   // R9 source cleared: transpose of zeros

        // Directed pattern: word encodes row and column.
        for (int r = 0; r < LANES; r++)
            for (int c = 0; c < LANES; c++) load_word(r, c, DATA_W'((r << 8) | c));
        run_xfer(1'b0);
        verify_all();

        // Random matrices.
        for (int k = 0; k < 3; k++) begin
            for (int r = 0; r < LANES; r++)
                for (int c = 0; c < LANES; c++) load_word(r, c, DATA_W'($urandom));
            run_xfer(k == 2);
            verify_all();
        end
        // R6: rerun without reload after a poked load; result unchanged.
        run_xfer(1'b0);
        verify_all();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule